// File: doc/BRIEF.md
# Single-Bus Processor Core

This block is a small processor core built around one shared internal bus. Every internal transfer travels over that bus, and only one source drives it in any cycle. The sources and sinks on the bus are a general register file, the program counter, the instruction register, a memory address register, a memory data register, two scratch registers and the ALU result register. The ALU takes its first operand from a two-way selector. One setting gives a scratch register loaded earlier from the bus. The other gives the hard-wired constant 4, which is how the program counter advances. The ALU result always goes to its own result register, and a later cycle puts that value back on the bus.

A hardwired step counter produces the gating signals. It runs the fetch phase in three steps: it issues the read and computes PC+4, then writes PC and waits for memory, then moves the fetched word into the instruction register. After that it runs a short execute sequence for the decoded operation and returns to step zero.

Memory is byte-addressed, and each instruction is one 32-bit word. The memory side is a request/acknowledge stream. The core raises a read or write request and holds the request, address and write data stable until the memory asserts the acknowledge. A memory that is not ready simply holds the acknowledge low, and that is the whole of the back-pressure. The core keeps its step counter frozen for as long as a request is outstanding. An acknowledge while no request is open has no effect.

Top module: `sbc_core`

## Requirements
- R1: While reset is asserted, no read or write request is raised. After reset is released, the first read request is for address 0.
- R2: Instruction words are read from consecutive addresses that step by 4. Instruction fields are: opcode in bits 31:28, destination register in bits 27:24, first source register in bits 23:20, second source register in bits 19:16, and immediate in bits 15:0.
- R3: A raised request keeps its address and write data stable until the acknowledge is sampled. It is dropped in the following cycle. The core never raises a read and a write request together.
- R4: At most one source drives the internal bus in any cycle.
- R5: Opcode 1 writes the sum of the two source registers, modulo 2^32, into the destination register.
- R6: Opcode 2 writes the first source minus the second source, modulo 2^32, into the destination register.
- R7: Opcode 3 copies the first source register into the destination register and leaves the source unchanged.
- R8: Opcode 7 writes the 16-bit immediate, zero-extended, into the destination register.
- R9: Opcode 4 reads the memory word at the address held in the first source register and writes it into the destination register.
- R10: Opcode 5 issues a write request whose address is the first source register and whose data is the second source register.
- R11: Opcode 6 makes the next instruction read come from the address held in the first source register.
- R12: Opcode 8 is a two-word instruction. It reads the following word from PC+4 into the destination register, and the next instruction is read from PC+8.
- R13: Opcodes 0 and 9 to 15 change no register and issue no data access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Byte address of the current request |
| mem_rd_req | output | 1 | Read request, held until acknowledged |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_wdata | output | 32 | Write data, driven from the memory data register |
| mem_rdata | input | 32 | Read data, captured in the cycle the read is acknowledged |
| mem_ack | input | 1 | Memory completion; ends the open request |

## Verification
The bench sweeps pairs of operands that include 0, 1, the largest positive value, the most negative value and all ones. It varies memory latency from zero to two wait cycles, so that carries, borrows and acknowledges arriving in the same cycle as the request are all exercised.

A core that latched the PC increment at the wrong step would show up as a skipped or repeated fetch address. A core that drove two bus sources at once would corrupt the stored sums. A core that dropped a request early, or let its address drift, would lose or misplace the store data. A core that decoded an undefined opcode as a register write would change the register that a later store reads back. The two-word load and the final jump are checked through the exact sequence of read addresses.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_MOV = 4'd3,
    OP_LD  = 4'd4,
    OP_ST  = 4'd5,
    OP_JMP = 4'd6,
    OP_LI  = 4'd7,
    OP_LIW = 4'd8
  } opcode_e;

  // One gating line per register transfer; *_out drive the bus, *_in load from it.
  typedef struct packed {
    logic pc_out;
    logic z_out;
    logic mdr_out;
    logic gpr_out;
    logic tmp_out;
    logic imm_out;
    logic pc_in;
    logic ir_in;
    logic mar_in;
    logic mdr_in;
    logic y_in;
    logic z_in;
    logic tmp_in;
    logic gpr_in;
    logic gpr_src2;  // register read port picks second source field
    logic sel4;      // ALU operand A: constant 4 instead of Y
    logic alu_sub;
    logic rd_start;
    logic wr_start;
    logic wait_mem;  // step holds until acknowledge
    logic last;      // step returns to zero
  } ctrl_t;

endpackage

// File: rtl/sbc_gpr.sv
module sbc_gpr #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (we && waddr == AW'(i)) begin
        regs[i] <= wdata;
      end
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/sbc_alu.sv
module sbc_alu #(
  parameter int DATA_W = 32
) (
  input  logic              sel4,
  input  logic              sub,
  input  logic [DATA_W-1:0] y_val,
  input  logic [DATA_W-1:0] b_val,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] a_val;

  // Operand A selector: scratch register Y or the fetch increment.
  assign a_val  = sel4 ? DATA_W'(4) : y_val;
  assign result = sub ? (a_val - b_val) : (a_val + b_val);

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  input  logic       mem_ack,
  output ctrl_t      ctl
);

  localparam logic [STEP_W-1:0] T0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] T1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] T2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] T3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] T4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] T5 = STEP_W'(5);

  logic [STEP_W-1:0] step;
  opcode_e           op;

  assign op = opcode_e'(opcode);

  always_comb begin
    ctl = '0;
    unique case (step)
      T0: begin  // address out, read, PC+4 into Z
        ctl.pc_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd_start = 1'b1;
        ctl.sel4 = 1'b1; ctl.z_in = 1'b1;
      end
      T1: begin
        ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.wait_mem = 1'b1;
      end
      T2: begin
        ctl.mdr_out = 1'b1; ctl.ir_in = 1'b1;
      end
      T3: begin
        unique case (op)
          OP_ADD, OP_SUB: begin ctl.gpr_out = 1'b1; ctl.y_in = 1'b1; end
          OP_MOV: begin ctl.gpr_out = 1'b1; ctl.tmp_in = 1'b1; end
          OP_LI: begin ctl.imm_out = 1'b1; ctl.gpr_in = 1'b1; ctl.last = 1'b1; end
          OP_LD: begin ctl.gpr_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd_start = 1'b1; end
          OP_ST: begin ctl.gpr_out = 1'b1; ctl.mar_in = 1'b1; end
          OP_JMP: begin ctl.gpr_out = 1'b1; ctl.pc_in = 1'b1; ctl.last = 1'b1; end
          OP_LIW: begin
            ctl.pc_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd_start = 1'b1;
            ctl.sel4 = 1'b1; ctl.z_in = 1'b1;
          end
          default: ctl.last = 1'b1;
        endcase
      end
      T4: begin
        unique case (op)
          OP_ADD, OP_SUB: begin
            ctl.gpr_out = 1'b1; ctl.gpr_src2 = 1'b1; ctl.z_in = 1'b1;
            ctl.alu_sub = (op == OP_SUB);
          end
          OP_MOV: begin ctl.tmp_out = 1'b1; ctl.gpr_in = 1'b1; ctl.last = 1'b1; end
          OP_LD: ctl.wait_mem = 1'b1;
          OP_ST: begin
            ctl.gpr_out = 1'b1; ctl.gpr_src2 = 1'b1; ctl.mdr_in = 1'b1;
            ctl.wr_start = 1'b1;
          end
          OP_LIW: begin ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.wait_mem = 1'b1; end
          default: ctl.last = 1'b1;
        endcase
      end
      T5: begin
        unique case (op)
          OP_ADD, OP_SUB: begin ctl.z_out = 1'b1; ctl.gpr_in = 1'b1; end
          OP_LD, OP_LIW: begin ctl.mdr_out = 1'b1; ctl.gpr_in = 1'b1; end
          OP_ST: ctl.wait_mem = 1'b1;
          default: ;
        endcase
        ctl.last = 1'b1;
      end
      default: ctl.last = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= T0;
    end else if (ctl.wait_mem && !mem_ack) begin
      step <= step;
    end else if (ctl.last) begin
      step <= T0;
    end else begin
      step <= step + STEP_W'(1);
    end
  end

endmodule

// File: rtl/sbc_core.sv
module sbc_core
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int RAW = $clog2(NREG);

  ctrl_t             c;
  logic [WORD_W-1:0] bus, alu_res, gpr_rd;
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] ir, mdr, y_r, z_r, tmp_r;
  logic              rd_pend, wr_pend;
  logic [RAW-1:0]    f_rd, f_rs1, f_rs2;

  assign f_rd  = ir[24 +: RAW];
  assign f_rs1 = ir[20 +: RAW];
  assign f_rs2 = ir[16 +: RAW];

  sbc_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(ir[31:28]), .mem_ack(mem_ack), .ctl(c)
  );

  sbc_gpr #(.NREG(NREG), .DATA_W(WORD_W)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(c.gpr_in), .waddr(f_rd), .wdata(bus),
    .raddr(c.gpr_src2 ? f_rs2 : f_rs1), .rdata(gpr_rd)
  );

  sbc_alu #(.DATA_W(WORD_W)) u_alu (
    .sel4(c.sel4), .sub(c.alu_sub), .y_val(y_r), .b_val(bus), .result(alu_res)
  );

  // Bus built as AND-OR of gated sources; the decoder enables at most one.
  always_comb begin
    bus = '0;
    if (c.pc_out)  bus = bus | WORD_W'(pc);
    if (c.z_out)   bus = bus | z_r;
    if (c.mdr_out) bus = bus | mdr;
    if (c.gpr_out) bus = bus | gpr_rd;
    if (c.tmp_out) bus = bus | tmp_r;
    if (c.imm_out) bus = bus | {16'b0, ir[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; ir <= '0; y_r <= '0; z_r <= '0; tmp_r <= '0;
    end else begin
      if (c.pc_in)  pc    <= bus[ADDR_W-1:0];
      if (c.mar_in) mar   <= bus[ADDR_W-1:0];
      if (c.ir_in)  ir    <= bus;
      if (c.y_in)   y_r   <= bus;
      if (c.z_in)   z_r   <= alu_res;
      if (c.tmp_in) tmp_r <= bus;
    end
  end

  // Memory data register: loaded from memory on a read acknowledge, else from the bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr <= '0;
    end else if (rd_pend && mem_ack) begin
      mdr <= mem_rdata;
    end else if (c.mdr_in) begin
      mdr <= bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      if (c.rd_start)    rd_pend <= 1'b1;
      else if (mem_ack)  rd_pend <= 1'b0;
      if (c.wr_start)    wr_pend <= 1'b1;
      else if (mem_ack)  wr_pend <= 1'b0;
    end
  end

  assign mem_addr   = mar;
  assign mem_rd_req = rd_pend;
  assign mem_wr_req = wr_pend;
  assign mem_wdata  = mdr;

  p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c.pc_out, c.z_out, c.mdr_out, c.gpr_out, c.tmp_out, c.imm_out}));

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_ack |=> mem_rd_req && $stable(mem_addr));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_ack |=> mem_wr_req && $stable(mem_addr) && $stable(mem_wdata));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) && mem_ack |=> !mem_rd_req && !mem_wr_req);

  p_no_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  p_pend_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> c.wait_mem);

  p_inc4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c.sel4 && c.z_in |=> z_r == $past(bus) + WORD_W'(4));

endmodule

// File: tb/test_sbc_core.sv
module test_sbc_core;

  localparam int CLK_P = 10;
  localparam logic [31:0] ST_ADDR = 32'h0000_00F0;
  localparam logic [31:0] LOOP_ADDR = 32'h0000_0048;
  localparam int NRD = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd_req, mem_wr_req, mem_ack;

  sbc_core i_sbc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] mem [64];
  int lat = 0, wcnt = 0;
  logic [31:0] rd_log [NRD];
  logic [31:0] wa_log [8], wd_log [8];
  int nrd = 0, nwr = 0, hold_err = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0;
  logic [31:0] prev_addr = '0, prev_wd = '0;

  initial mem_ack = 1'b0;
  initial mem_rdata = '0;

  // Memory model, evaluated at the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n && (mem_rd_req || mem_wr_req)) begin
      if (prev_req && !prev_ack &&
          (mem_addr != prev_addr || (mem_wr_req && mem_wdata != prev_wd)))
        hold_err++;
      if (mem_rd_req && mem_wr_req) hold_err++;
      prev_req = 1'b1; prev_addr = mem_addr; prev_wd = mem_wdata;
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mem_rd_req) begin
          mem_rdata = mem[mem_addr[7:2]];
          if (nrd < NRD) rd_log[nrd] = mem_addr;
          nrd++;
        end else begin
          mem[mem_addr[7:2]] = mem_wdata;
          if (nwr < 8) begin wa_log[nwr] = mem_addr; wd_log[nwr] = mem_wdata; end
          nwr++;
        end
      end else begin
        mem_ack = 1'b0;
        wcnt++;
      end
      prev_ack = mem_ack;
    end else begin
      mem_ack = 1'b0; wcnt = 0; prev_req = 1'b0; prev_ack = 1'b0;
    end
  end

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                      input logic [3:0] s1, input logic [3:0] s2,
                                      input logic [15:0] imm);
    return {op, rd, s1, s2, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] a, input logic [31:0] b, input int l);
    logic [31:0] exp_rd [NRD];
    logic [31:0] exp_wd [6];
    int n, guard;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = enc(4'd8, 4'd1, 4'd0, 4'd0, 16'h0);
    mem[1]  = a;
    mem[2]  = enc(4'd8, 4'd2, 4'd0, 4'd0, 16'h0);
    mem[3]  = b;
    mem[4]  = enc(4'd1, 4'd3, 4'd1, 4'd2, 16'h0);
    mem[5]  = enc(4'd2, 4'd4, 4'd1, 4'd2, 16'h0);
    mem[6]  = enc(4'd3, 4'd5, 4'd1, 4'd0, 16'h0);
    mem[7]  = enc(4'd7, 4'd7, 4'd0, 4'd0, ST_ADDR[15:0]);
    mem[8]  = enc(4'd5, 4'd0, 4'd7, 4'd3, 16'h0);
    mem[9]  = enc(4'd5, 4'd0, 4'd7, 4'd4, 16'h0);
    mem[10] = enc(4'd5, 4'd0, 4'd7, 4'd5, 16'h0);
    mem[11] = enc(4'd5, 4'd0, 4'd7, 4'd1, 16'h0);
    mem[12] = enc(4'd4, 4'd6, 4'd7, 4'd0, 16'h0);
    mem[13] = enc(4'd7, 4'd5, 4'd0, 4'd0, b[15:0]);
    mem[14] = enc(4'hA, 4'd5, 4'd1, 4'd2, 16'h1234);  // undefined opcode
    mem[15] = enc(4'd5, 4'd0, 4'd7, 4'd5, 16'h0);
    mem[16] = enc(4'd5, 4'd0, 4'd7, 4'd6, 16'h0);
    mem[17] = enc(4'd7, 4'd0, 4'd0, 4'd0, LOOP_ADDR[15:0]);
    mem[18] = enc(4'd6, 4'd0, 4'd0, 4'd0, 16'h0);
    lat = l; nrd = 0; nwr = 0; hold_err = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check("R1 read during reset", {31'b0, mem_rd_req}, 32'd0);
    check("R1 write during reset", {31'b0, mem_wr_req}, 32'd0);
    rst_n = 1'b1;
    guard = 0;
    while (nrd < NRD && guard < 3000) begin @(posedge clk); guard++; end
    if (guard >= 3000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d reads expected %0d", nrd, NRD);
      return;
    end
    // Expected read address sequence.
    n = 0;
    for (int w = 0; w < 19; w++) begin
      exp_rd[n++] = 32'(4 * w);
      if (w == 12) exp_rd[n++] = ST_ADDR;
    end
    while (n < NRD) exp_rd[n++] = LOOP_ADDR;
    for (int i = 0; i < NRD; i++) begin
      if (i == 0)                check("R1 first read", rd_log[i], exp_rd[i]);
      else if (i == 1 || i == 3) check("R12 second word", rd_log[i], exp_rd[i]);
      else if (i == 2 || i == 4) check("R12 next after two-word", rd_log[i], exp_rd[i]);
      else if (i == 13)          check("R9 load address", rd_log[i], exp_rd[i]);
      else if (i >= 20)          check("R11 jump target", rd_log[i], exp_rd[i]);
      else                       check("R2 fetch address", rd_log[i], exp_rd[i]);
    end
    exp_wd[0] = a + b;
    exp_wd[1] = a - b;
    exp_wd[2] = a;
    exp_wd[3] = a;
    exp_wd[4] = {16'b0, b[15:0]};
    exp_wd[5] = a;
    check("R10 write count", 32'(nwr), 32'd6);
    for (int i = 0; i < 6; i++) check("R10 write address", wa_log[i], ST_ADDR);
    check("R4 R5 sum", wd_log[0], exp_wd[0]);
    check("R6 difference", wd_log[1], exp_wd[1]);
    check("R7 copy", wd_log[2], exp_wd[2]);
    check("R7 source kept", wd_log[3], exp_wd[3]);
    check("R8 R13 immediate kept over undefined op", wd_log[4], exp_wd[4]);
    check("R9 loaded word", wd_log[5], exp_wd[5]);
    check("R3 request hold", 32'(hold_err), 32'd0);
  endtask

  initial begin
    logic [31:0] vals [6];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_ABCD;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        run_case(vals[i], vals[j], (i + j) % 3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule